// File: doc/BRIEF.md
# Optimal-Extension-Field Inversion Sequencer

This block returns the multiplicative inverse of a nonzero element A of the extension field GF(239^17). Elements are held as polynomials of degree below 17. Each coefficient lies in GF(239), and the field is reduced by the binomial x^17 − 2. The inversion uses a fixed exponentiation chain that computes A^(r−1), where r = (p^17 − 1)/(p − 1). The chain interleaves five Frobenius powerings with four full field multiplies. The product A·A^(r−1) = A^r always lies in the base field GF(239). The block therefore forms only the constant coefficient of that product, with an internal serial dot product. It inverts that byte through a table built when the design is elaborated. Finally it scales A^(r−1) by the byte inverse.

The block does not contain a full field multiplier. It issues each of its four multiplies to an external multiplier. It raises a one-cycle request with both operands and waits for a completion pulse that carries the product. It keeps the operands steady while a multiply is outstanding. A host loads the operand, pulses start and reads the result once the done flag rises. The result and the done flag then hold until the next accepted start.

Top module: `oef_inverter`

## Requirements
- R1: While reset is applied and after reset is released, done is 0 and result is all zeros.
- R2: For a loaded nonzero A, the finished result R satisfies R·A = 1 modulo x^17 − 2 over GF(239). Coefficient j of every element bus occupies bits [8j+7:8j], and every result coefficient is below 239.
- R3: Let L be the number of clock edges from the edge that samples mulStart to the edge that samples mulDone. Then done rises exactly 27 + 4·L edges after the edge that samples start.
- R4: Each inversion issues exactly four multiply requests, and each mulStart lasts one cycle. mulOpA and mulOpB stay constant from the request until the edge that samples mulDone.
- R5: mulStart is never raised while an earlier multiply is still outstanding.
- R6: While done is high and no start arrives, done and result hold their values.
- R7: loadEn and start are ignored while an inversion is running. The result still inverts the operand loaded before the accepted start, and the timing of R3 is unchanged.
- R8: The first request carries mulOpA = A^p and mulOpB = A. Raising to p multiplies coefficient j by 2^(14j) mod 239: coefficient 0 by 1, coefficient 1 by 132 and coefficient 2 by 216.
- R9: The following requests carry (B1^(p^2), B1), then (B3^(p^4), B3), then (B5^(p^8), B5). Here Bk is the product returned by the previous request. Raising to p^k multiplies coefficient j by 2^(14kj mod 238) mod 239.
- R10: An operand whose only nonzero coefficient is coefficient 0 gives a result with coefficient 0 equal to the inverse of that value mod 239 and all other coefficients zero (1→1, 2→120, 238→238). The operand x gives 120·x^16.
- R11: done falls at the edge that samples an accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Captures loadData as the operand while idle |
| loadData | input | 136 | Operand A, 17 coefficients of 8 bits |
| start | input | 1 | Starts an inversion while idle |
| done | output | 1 | Result valid; held until the next accepted start |
| result | output | 136 | Inverse of A, 17 coefficients of 8 bits |
| mulStart | output | 1 | One-cycle request to the external multiplier |
| mulOpA | output | 136 | First multiplier operand |
| mulOpB | output | 136 | Second multiplier operand |
| mulDone | input | 1 | Completion pulse from the external multiplier |
| mulProd | input | 136 | Product, valid while mulDone is high |

## Verification
The done flag is due exactly 27 + 4·L edges after the edge that accepts start, where L is the latency of the bench multiplier. The bench model counts that window at every rising edge and compares done at every falling edge, including runs with L from 1 to 4. Multiplier operands are compared at the falling edge of each request cycle against a chain the bench recomputes from A. The result is checked one falling edge after done rises, by multiplying it with A. It is checked again three cycles later to confirm that it holds, and a run disturbed by a mid-flight load and start must keep the same timing and result.

// File: rtl/oef_inv_pkg.sv
package oef_inv_pkg;
  parameter int FIELD_P = 239;
  parameter int COEF_W = 8;
  parameter int DEG = 17;
  parameter int OMEGA = 2;

  localparam int ELEM_W = DEG * COEF_W;
  localparam int IDX_W = $clog2(DEG);
  localparam int PROD_W = 2 * COEF_W;
  localparam int TERM_W = PROD_W + $clog2(OMEGA) + 1;
  localparam int DOT_MAX = (2 * DEG - 1) * (FIELD_P - 1) * (FIELD_P - 1);
  localparam int DOT_W = $clog2(DOT_MAX + 1);
  localparam int LUT_N = 1 << COEF_W;

  typedef logic [COEF_W-1:0] coef_t;
  typedef coef_t [DEG-1:0] elem_t;

  // exponent p^(2^k) selector for the Frobenius unit
  typedef enum logic [1:0] {FROB_X1, FROB_X2, FROB_X4, FROB_X8} frob_pow_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FRA, ST_MULA, ST_WTA, ST_FRB, ST_MULB, ST_WTB, ST_FRC,
    ST_MULC, ST_WTC, ST_FRD, ST_MULD, ST_WTD, ST_FRE, ST_DOT, ST_SCALE
  } seq_state_e;

  typedef struct packed {
    logic             opLoad;
    logic             frobLoad;
    logic             frobFromAcc;
    frob_pow_e        frobSel;
    logic             mulFromAcc;
    logic             accLoad;
    logic             dotClear;
    logic             dotStep;
    logic [IDX_W-1:0] dotIdx;
    logic             scaleLoad;
  } dp_strobe_t;

  function automatic int mod_pow(int base, int e);
    int r = 1;
    int b = base % FIELD_P;
    for (int i = 0; i < 31; i++) begin
      if (e[i]) r = (r * b) % FIELD_P;
      b = (b * b) % FIELD_P;
    end
    return r;
  endfunction

  // constant that raises coefficient j to the p^(2^powSel) power
  function automatic int frob_const(int powSel, int j);
    int step = (FIELD_P - 1) / DEG;
    int e = (j * (1 << powSel) * step) % (FIELD_P - 1);
    return mod_pow(OMEGA, e);
  endfunction

  function automatic int sub_inverse(int a);
    if (a % FIELD_P == 0) return 0;
    return mod_pow(a, FIELD_P - 2);
  endfunction
endpackage

// File: rtl/oef_inv_frob.sv
module oef_inv_frob
  import oef_inv_pkg::*;
(
  input  elem_t     srcElem,
  input  frob_pow_e powSel,
  output elem_t     dstElem
);
  for (genvar j = 0; j < DEG; j++) begin : g_coef
    localparam coef_t K1 = coef_t'(frob_const(0, j));
    localparam coef_t K2 = coef_t'(frob_const(1, j));
    localparam coef_t K4 = coef_t'(frob_const(2, j));
    localparam coef_t K8 = coef_t'(frob_const(3, j));
    coef_t kSel;
    logic [PROD_W-1:0] prod;

    always_comb begin
      case (powSel)
        FROB_X1: kSel = K1;
        FROB_X2: kSel = K2;
        FROB_X4: kSel = K4;
        default: kSel = K8;
      endcase
    end

    assign prod = PROD_W'(srcElem[j]) * PROD_W'(kSel);
    assign dstElem[j] = coef_t'(prod % PROD_W'(FIELD_P));
  end
endmodule

// File: rtl/oef_inv_dp.sv
module oef_inv_dp
  import oef_inv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dp_strobe_t ctl,
  input  elem_t      loadData,
  input  elem_t      mulProd,
  output elem_t      mulOpA,
  output elem_t      mulOpB,
  output elem_t      result
);
  elem_t aReg, frobReg, accReg, resReg;
  elem_t frobSrc, frobOut, scaled;
  logic [DOT_W-1:0] dotAcc;
  coef_t dotRed, dotInv;
  coef_t invLut [LUT_N];

  // subfield inverse table, computed at elaboration
  for (genvar v = 0; v < LUT_N; v++) begin : g_lut
    assign invLut[v] = coef_t'(sub_inverse(v));
  end

  assign frobSrc = ctl.frobFromAcc ? accReg : aReg;

  oef_inv_frob i_frob (
    .srcElem(frobSrc),
    .powSel (ctl.frobSel),
    .dstElem(frobOut)
  );

  // one term of the constant coefficient of B8*A per cycle
  logic [IDX_W-1:0] partner;
  logic [PROD_W-1:0] prodBA;
  logic [TERM_W-1:0] term;

  always_comb begin
    partner = (ctl.dotIdx == '0) ? '0 : IDX_W'(DEG) - ctl.dotIdx;
    prodBA = PROD_W'(frobReg[ctl.dotIdx]) * PROD_W'(aReg[partner]);
    if (ctl.dotIdx == '0) term = TERM_W'(prodBA);
    else term = TERM_W'(prodBA) * TERM_W'(OMEGA);
  end

  assign dotRed = coef_t'(dotAcc % DOT_W'(FIELD_P));
  assign dotInv = invLut[dotRed];

  for (genvar j = 0; j < DEG; j++) begin : g_scale
    logic [PROD_W-1:0] sp;
    assign sp = PROD_W'(dotInv) * PROD_W'(frobReg[j]);
    assign scaled[j] = coef_t'(sp % PROD_W'(FIELD_P));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aReg    <= '0;
      frobReg <= '0;
      accReg  <= '0;
      resReg  <= '0;
      dotAcc  <= '0;
    end else begin
      if (ctl.opLoad) aReg <= loadData;
      if (ctl.frobLoad) frobReg <= frobOut;
      if (ctl.accLoad) accReg <= mulProd;
      if (ctl.dotClear) dotAcc <= '0;
      else if (ctl.dotStep) dotAcc <= dotAcc + DOT_W'(term);
      if (ctl.scaleLoad) resReg <= scaled;
    end
  end

  assign mulOpA = frobReg;
  assign mulOpB = ctl.mulFromAcc ? accReg : aReg;
  assign result = resReg;
endmodule

// File: rtl/oef_inv_ctrl.sv
module oef_inv_ctrl
  import oef_inv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       loadEn,
  input  logic       mulDone,
  output dp_strobe_t ctl,
  output logic       mulStart,
  output logic       done
);
  seq_state_e state, nextState;
  logic [IDX_W-1:0] dotIdx;

  always_comb begin
    ctl = '0;
    ctl.dotIdx = dotIdx;
    ctl.opLoad = loadEn && (state == ST_IDLE);
    mulStart = 1'b0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) nextState = ST_FRA;
      ST_FRA: begin
        ctl.frobLoad = 1'b1;
        ctl.frobSel = FROB_X1;
        nextState = ST_MULA;
      end
      ST_MULA: begin
        mulStart = 1'b1;
        nextState = ST_WTA;
      end
      ST_WTA: if (mulDone) begin
        ctl.accLoad = 1'b1;
        nextState = ST_FRB;
      end
      ST_FRB: begin
        ctl.frobLoad = 1'b1;
        ctl.frobFromAcc = 1'b1;
        ctl.frobSel = FROB_X2;
        nextState = ST_MULB;
      end
      ST_MULB: begin
        mulStart = 1'b1;
        ctl.mulFromAcc = 1'b1;
        nextState = ST_WTB;
      end
      ST_WTB: begin
        ctl.mulFromAcc = 1'b1;
        if (mulDone) begin
          ctl.accLoad = 1'b1;
          nextState = ST_FRC;
        end
      end
      ST_FRC: begin
        ctl.frobLoad = 1'b1;
        ctl.frobFromAcc = 1'b1;
        ctl.frobSel = FROB_X4;
        nextState = ST_MULC;
      end
      ST_MULC: begin
        mulStart = 1'b1;
        ctl.mulFromAcc = 1'b1;
        nextState = ST_WTC;
      end
      ST_WTC: begin
        ctl.mulFromAcc = 1'b1;
        if (mulDone) begin
          ctl.accLoad = 1'b1;
          nextState = ST_FRD;
        end
      end
      ST_FRD: begin
        ctl.frobLoad = 1'b1;
        ctl.frobFromAcc = 1'b1;
        ctl.frobSel = FROB_X8;
        nextState = ST_MULD;
      end
      ST_MULD: begin
        mulStart = 1'b1;
        ctl.mulFromAcc = 1'b1;
        nextState = ST_WTD;
      end
      ST_WTD: begin
        ctl.mulFromAcc = 1'b1;
        if (mulDone) begin
          ctl.accLoad = 1'b1;
          nextState = ST_FRE;
        end
      end
      ST_FRE: begin
        ctl.frobLoad = 1'b1;
        ctl.frobFromAcc = 1'b1;
        ctl.frobSel = FROB_X1;
        ctl.dotClear = 1'b1;
        nextState = ST_DOT;
      end
      ST_DOT: begin
        ctl.dotStep = 1'b1;
        if (dotIdx == IDX_W'(DEG - 1)) nextState = ST_SCALE;
      end
      ST_SCALE: begin
        ctl.scaleLoad = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dotIdx <= '0;
      done   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_FRE) dotIdx <= '0;
      else if (state == ST_DOT) dotIdx <= dotIdx + 1'b1;
      if (state == ST_SCALE) done <= 1'b1;
      else if (state == ST_IDLE && start) done <= 1'b0;
    end
  end
endmodule

// File: rtl/oef_inverter.sv
module oef_inverter
  import oef_inv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic [ELEM_W-1:0] loadData,
  input  logic              start,
  output logic              done,
  output logic [ELEM_W-1:0] result,
  output logic              mulStart,
  output logic [ELEM_W-1:0] mulOpA,
  output logic [ELEM_W-1:0] mulOpB,
  input  logic              mulDone,
  input  logic [ELEM_W-1:0] mulProd
);
  dp_strobe_t ctl;
  elem_t opAElem, opBElem, resElem;

  oef_inv_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .loadEn  (loadEn),
    .mulDone (mulDone),
    .ctl     (ctl),
    .mulStart(mulStart),
    .done    (done)
  );

  oef_inv_dp i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .loadData(elem_t'(loadData)),
    .mulProd (elem_t'(mulProd)),
    .mulOpA  (opAElem),
    .mulOpB  (opBElem),
    .result  (resElem)
  );

  assign mulOpA = opAElem;
  assign mulOpB = opBElem;
  assign result = resElem;
endmodule

// File: rtl/oef_inverter_chk.sv
module oef_inverter_chk
  import oef_inv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [ELEM_W-1:0] result,
  input logic              mulStart,
  input logic [ELEM_W-1:0] mulOpA,
  input logic [ELEM_W-1:0] mulOpB,
  input logic              mulDone
);
  logic mulOpen;
  logic doneQ;
  logic [2:0] mulCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mulOpen <= 1'b0;
      doneQ   <= 1'b0;
      mulCnt  <= '0;
    end else begin
      doneQ <= done;
      if (mulStart) mulOpen <= 1'b1;
      else if (mulDone) mulOpen <= 1'b0;
      if (done && !doneQ) mulCnt <= '0;
      else if (mulStart) mulCnt <= mulCnt + 1'b1;
    end
  end

  function automatic logic allBelowP(logic [ELEM_W-1:0] e);
    for (int j = 0; j < DEG; j++)
      if (int'(e[j*COEF_W +: COEF_W]) >= FIELD_P) return 1'b0;
    return 1'b1;
  endfunction

  // R4
  mul_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mulStart |=> !mulStart);

  // R5
  mul_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mulOpen |-> !mulStart);

  // R4
  mul_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mulOpen |-> ($stable(mulOpA) && $stable(mulOpB)));

  // R4
  mul_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !doneQ) |-> (mulCnt == 3'd4));

  // R2
  coef_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> allBelowP(result));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && doneQ) |-> $stable(result));

  // R11
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> !done);
endmodule

bind oef_inverter oef_inverter_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .done    (done),
  .result  (result),
  .mulStart(mulStart),
  .mulOpA  (mulOpA),
  .mulOpB  (mulOpB),
  .mulDone (mulDone)
);

// File: tb/test_oef_inverter.sv
module test_oef_inverter;
  import oef_inv_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int FIX_CYCLES = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadEn = 1'b0;
  logic start = 1'b0;
  logic [ELEM_W-1:0] loadData = '0;
  logic done, mulStart, mulDone;
  logic [ELEM_W-1:0] result, mulOpA, mulOpB, mulProd;

  always #(CLK_PERIOD/2) clk = ~clk;

  oef_inverter i_oef_inverter (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadData(loadData),
    .start(start), .done(done), .result(result), .mulStart(mulStart),
    .mulOpA(mulOpA), .mulOpB(mulOpB), .mulDone(mulDone), .mulProd(mulProd)
  );

  int nCmp = 0;
  int nBad = 0;
  int mulLat = 1;
  int mulSeen = 0;
  logic [ELEM_W-1:0] expA [4];
  logic [ELEM_W-1:0] expB [4];

  function automatic int cf(logic [ELEM_W-1:0] e, int j);
    return int'(e[j*COEF_W +: COEF_W]);
  endfunction

  function automatic int powMod(int b, int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * b) % 239;
    return r;
  endfunction

  function automatic logic [ELEM_W-1:0] polyMul(logic [ELEM_W-1:0] a, logic [ELEM_W-1:0] b);
    int acc [17];
    logic [ELEM_W-1:0] r;
    for (int k = 0; k < 17; k++) acc[k] = 0;
    for (int i = 0; i < 17; i++)
      for (int j = 0; j < 17; j++) begin
        if (i + j >= 17) acc[i+j-17] += 2 * cf(a, i) * cf(b, j);
        else acc[i+j] += cf(a, i) * cf(b, j);
      end
    for (int k = 0; k < 17; k++) r[k*8 +: 8] = 8'(acc[k] % 239);
    return r;
  endfunction

  // raise to p^k: coefficient j times 2^(14*k*j mod 238)
  function automatic logic [ELEM_W-1:0] frobB(logic [ELEM_W-1:0] a, int k);
    logic [ELEM_W-1:0] r;
    for (int j = 0; j < 17; j++)
      r[j*8 +: 8] = 8'((cf(a, j) * powMod(2, (14 * k * j) % 238)) % 239);
    return r;
  endfunction

  function automatic logic [ELEM_W-1:0] mkCoef(int pos, int v);
    logic [ELEM_W-1:0] r = '0;
    r[pos*8 +: 8] = 8'(v);
    return r;
  endfunction

  task automatic chkElem(string tag, string what, logic [ELEM_W-1:0] act, logic [ELEM_W-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chkInt(string tag, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural multiplier with programmable latency
  logic [ELEM_W-1:0] prodQ = '0;
  int mulLeft = 0;
  always @(posedge clk) begin
    if (mulStart) begin
      prodQ <= polyMul(mulOpA, mulOpB);
      mulLeft <= mulLat;
    end else if (mulLeft > 0) mulLeft <= mulLeft - 1;
  end
  assign mulDone = (mulLeft == 1);
  assign mulProd = prodQ;

  // reference timing model for done
  bit doneExp = 1'b0;
  bit busyExp = 1'b0;
  int leftExp = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      doneExp = 1'b0;
      busyExp = 1'b0;
    end else if (busyExp) begin
      leftExp--;
      if (leftExp == 0) begin
        busyExp = 1'b0;
        doneExp = 1'b1;
      end
    end else if (start) begin
      busyExp = 1'b1;
      doneExp = 1'b0;
      leftExp = FIX_CYCLES + 4 * mulLat;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chkInt("R3", "done level", int'(done), int'(doneExp));
      if (mulStart) begin
        chkInt("R5", "request while outstanding", mulLeft, 0);
        if (mulSeen < 4) begin
          chkElem(mulSeen == 0 ? "R8" : "R9", "mulOpA", mulOpA, expA[mulSeen]);
          chkElem(mulSeen == 0 ? "R8" : "R9", "mulOpB", mulOpB, expB[mulSeen]);
        end
        mulSeen++;
      end
    end
  end

  task automatic runInv(logic [ELEM_W-1:0] a, int lat, bit disturb, bit haveExp, logic [ELEM_W-1:0] expRes);
    logic [ELEM_W-1:0] b1, b3, b5, held;
    int w = 0;
    mulLat = lat;
    expA[0] = frobB(a, 1);  expB[0] = a;
    b1 = polyMul(expA[0], a);
    expA[1] = frobB(b1, 2); expB[1] = b1;
    b3 = polyMul(expA[1], b1);
    expA[2] = frobB(b3, 4); expB[2] = b3;
    b5 = polyMul(expA[2], b3);
    expA[3] = frobB(b5, 8); expB[3] = b5;
    mulSeen = 0;
    @(negedge clk); loadEn = 1'b1; loadData = a;
    @(negedge clk); loadEn = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chkInt("R11", "done after start", int'(done), 0);
    if (disturb) begin
      repeat (3) @(negedge clk);
      loadEn = 1'b1; loadData = mkCoef(3, 77) | mkCoef(0, 5); start = 1'b1;
      @(negedge clk); loadEn = 1'b0; start = 1'b0;
    end
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (!done) chkInt("R3", "watchdog on done", 0, 1);
    chkInt("R4", "request count", mulSeen, 4);
    chkElem(disturb ? "R7" : "R2", "result times A", polyMul(result, a), mkCoef(0, 1));
    if (haveExp) chkElem("R10", "exact inverse", result, expRes);
    held = result;
    repeat (3) @(negedge clk);
    chkElem("R6", "result held", result, held);
    chkInt("R6", "done held", int'(done), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [ELEM_W-1:0] rnd;
    repeat (3) @(negedge clk);
    chkInt("R1", "done in reset", int'(done), 0);
    chkElem("R1", "result in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chkInt("R1", "done after reset", int'(done), 0);
    chkElem("R1", "result after reset", result, '0);

    runInv(mkCoef(0, 1), 1, 1'b0, 1'b1, mkCoef(0, 1));
    runInv(mkCoef(0, 2), 2, 1'b0, 1'b1, mkCoef(0, 120));
    runInv(mkCoef(0, 238), 3, 1'b0, 1'b1, mkCoef(0, 238));
    runInv(mkCoef(1, 1), 1, 1'b0, 1'b1, mkCoef(16, 120));
    for (int t = 0; t < 8; t++) begin
      rnd = '0;
      for (int j = 0; j < 17; j++) rnd[j*8 +: 8] = 8'($urandom % 239);
      rnd[7:0] = 8'(1 + $urandom % 238);
      runInv(rnd, 1 + t % 4, 1'b0, 1'b0, '0);
    end
    rnd = '0;
    for (int j = 0; j < 17; j++) rnd[j*8 +: 8] = 8'(238 - j);
    runInv(rnd, 2, 1'b1, 1'b0, '0);
    runInv(mkCoef(2, 9) | mkCoef(16, 200), 4, 1'b1, 1'b0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule